// File: doc/BRIEF.md
# DRAM Bring-Up Status Register Block

This block stands in for the control and status side of a DRAM controller while boot firmware brings memory up. It presents a bank of 32-bit registers on a simple single-cycle bus and reports what the firmware expects to see. Any write to the PHY start register immediately flags initialization complete and the controller as running. A separate probe window stands for the address space of a second rank that is not fitted. Reading it returns zero, and if the firmware has armed the read-timeout feature, the read also latches a timeout flag. The rank-count probe then fails cleanly.

Accesses are full 32-bit words addressed by word index (byte offset divided by 4). The `bus_win` pin selects the control window (0) or the probe window (1). Read data appears on `bus_rdata` in the cycle after the request and is held until the next read. No DRAM commands, PHY training or timing are generated.

Top module: `dram_stat_regs`

## Requirements
- R1: After reset every implemented control register reads as zero, and `bus_rdata` is zero.
- R2: A control-window write to an in-range word index stores the data. A later read of that index returns it on `bus_rdata` one cycle after the request.
- R3: A control-window write to word 0 (PHY start) ORs 1 into bit 0 of word 4 (PHY status, init done) and into bit 0 of word 6 (controller status, active). All other bits of those words keep their values.
- R4: The data written to word 0 is itself stored in word 0 after the side effects, and reads back unchanged.
- R5: Every read in the probe window (`bus_win`=1) returns zero on `bus_rdata`, whatever the address.
- R6: A probe-window read sets bit 13 (read timeout) of word 4 when bit 25 of word 64 (PHY configuration) is 1. When bit 25 is 0, bit 13 is left unchanged.
- R7: Once set, bit 13 of word 4 stays set through further probe reads, whether or not the timeout is armed.
- R8: A control-window read of a word index at or beyond `NUM_REGS` returns zero. A write to such an index changes no register.
- R9: Writes in the probe window change no register and have no PHY-start side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = control window, 1 = probe window |
| bus_addr | input | 10 | Word index within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |

## Verification
The bench builds the block with its default `NUM_REGS` of 72. With that value the whole 1024-entry address space of both windows can be swept in a few thousand cycles. Every in-range word is written with a distinct computed pattern and read back. Every out-of-range index, from 72 to 1023, is both written and read, which shows that out-of-range writes do not alias onto implemented words. The timeout sequence is run with the enable bit both cleared and set. It uses probe reads across the full probe address range, and checks that the sticky flag survives later probe reads with the enable bit cleared.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int DATA_W     = 32;
    localparam int IDX_START  = 0;
    localparam int IDX_PSTAT  = 4;
    localparam int IDX_CSTAT  = 6;
    localparam int IDX_PCFG   = 64;
    localparam int BIT_DONE   = 0;
    localparam int BIT_ACTIVE = 0;
    localparam int BIT_TMO    = 13;
    localparam int BIT_TMO_EN = 25;

    typedef struct packed {
        logic ctl_wr;
        logic ctl_rd;
        logic prb_rd;
        logic in_range;
    } dsr_dec_t;
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
    import dsr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 72
) (
    input  logic              vld,
    input  logic              we,
    input  logic              win,
    input  logic [ADDR_W-1:0] addr,
    output dsr_dec_t          dec
);
    localparam int PAD_W = 32 - ADDR_W;

    always_comb begin
        dec          = '0;
        dec.in_range = ({{PAD_W{1'b0}}, addr} < 32'(NUM_REGS));
        dec.ctl_wr   = vld && we && !win && dec.in_range;
        dec.ctl_rd   = vld && !we && !win;
        dec.prb_rd   = vld && !we && win;
    end
endmodule

// File: rtl/dsr_probe.sv
module dsr_probe
    import dsr_pkg::*;
(
    input  logic              prb_rd,
    input  logic [DATA_W-1:0] cfg_word,
    output logic              tmo_set
);
    always_comb begin
        tmo_set = prb_rd && cfg_word[BIT_TMO_EN];
    end
endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
    import dsr_pkg::*;
#(
    parameter int NUM_REGS = 72,
    parameter int IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tmo_set,
    input  logic              rd_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] pstat,
    output logic [DATA_W-1:0] cstat,
    output logic [DATA_W-1:0] pcfg
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] word;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_idx == IDX_W'(IDX_START)) begin
                st_d.word[IDX_PSTAT][BIT_DONE]   = 1'b1;
                st_d.word[IDX_CSTAT][BIT_ACTIVE] = 1'b1;
            end
            st_d.word[wr_idx] = wr_data;
        end
        if (tmo_set) begin
            st_d.word[IDX_PSTAT][BIT_TMO] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = rd_ok ? st_q.word[rd_idx] : '0;
        pstat   = st_q.word[IDX_PSTAT];
        cstat   = st_q.word[IDX_CSTAT];
        pcfg    = st_q.word[IDX_PCFG];
    end
endmodule

// File: rtl/dram_stat_regs.sv
module dram_stat_regs
    import dsr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    dsr_dec_t          dec;
    logic              tmo_set;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] pstat_w;
    logic [DATA_W-1:0] cstat_w;
    logic [DATA_W-1:0] pcfg_w;
    top_t              top_d, top_q;

    dsr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .vld  (bus_vld),
        .we   (bus_we),
        .win  (bus_win),
        .addr (bus_addr),
        .dec  (dec)
    );

    dsr_probe u_prb (
        .prb_rd   (dec.prb_rd),
        .cfg_word (pcfg_w),
        .tmo_set  (tmo_set)
    );

    dsr_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dec.ctl_wr),
        .wr_idx  (bus_addr[IDX_W-1:0]),
        .wr_data (bus_wdata),
        .tmo_set (tmo_set),
        .rd_ok   (dec.in_range),
        .rd_idx  (bus_addr[IDX_W-1:0]),
        .rd_word (rd_word),
        .pstat   (pstat_w),
        .cstat   (cstat_w),
        .pcfg    (pcfg_w)
    );

    always_comb begin
        top_d = top_q;
        if (dec.ctl_rd) begin
            top_d.rdata = rd_word;
        end
        if (dec.prb_rd) begin
            top_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
    import dsr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_vld,
    input logic              bus_we,
    input logic              bus_win,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pstat,
    input logic [31:0]       cstat,
    input logic [31:0]       pcfg
);
    localparam int PAD_W = 32 - ADDR_W;

    logic start_wr, pstat_wr, prb_rd, prb_wr, oor_rd;

    always_comb begin
        start_wr = bus_vld && bus_we && !bus_win && (bus_addr == '0);
        pstat_wr = bus_vld && bus_we && !bus_win && (bus_addr == ADDR_W'(IDX_PSTAT));
        prb_rd   = bus_vld && !bus_we && bus_win;
        prb_wr   = bus_vld && bus_we && bus_win;
        oor_rd   = bus_vld && !bus_we && !bus_win &&
                   ({{PAD_W{1'b0}}, bus_addr} >= 32'(NUM_REGS));
    end

    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> pstat[BIT_DONE]);
    p_active_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> cstat[BIT_ACTIVE]);
    p_probe_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prb_rd |=> (bus_rdata == '0));
    p_tmo_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_rd && pcfg[BIT_TMO_EN]) |=> pstat[BIT_TMO]);
    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pstat[BIT_TMO] && !pstat_wr) |=> pstat[BIT_TMO]);
    p_oor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oor_rd |=> (bus_rdata == '0));
    p_probe_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prb_wr |=> ($stable(pstat) && $stable(cstat) && $stable(pcfg)));
endmodule

bind dram_stat_regs dsr_checker #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pstat     (pstat_w),
    .cstat     (cstat_w),
    .pcfg      (pcfg_w)
);

// File: tb/sim_dram_stat_regs.sv
module sim_dram_stat_regs;
    localparam int AW = 10;
    localparam int NR = 72;
    localparam int SPACE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_vld = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_win = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_stat_regs #(.ADDR_W(AW), .NUM_REGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h0000_00C3;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(bit win, int a, logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_we = 1'b1; bus_win = win;
        bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(bit win, int a, output logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_we = 1'b0; bus_win = win; bus_addr = AW'(a);
        @(negedge clk);
        bus_vld = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // R1 / R8: every index reads zero after reset
        for (int i = 0; i < SPACE; i++) begin
            rd(1'b0, i, v);
            chk(i < NR ? "R1 reset value" : "R8 out-of-range read", v, 32'h0);
        end

        // R2 / R4: ascending sweep; later writes to 4 and 6 overwrite side effects
        for (int i = 0; i < NR; i++) wr(1'b0, i, pat(i));
        for (int i = 0; i < NR; i++) begin
            rd(1'b0, i, v);
            chk(i == 0 ? "R4 start word stored" : "R2 readback", v, pat(i));
        end

        // R8: out-of-range writes change nothing and read zero
        for (int i = NR; i < SPACE; i++) wr(1'b0, i, ~pat(i));
        for (int i = 0; i < SPACE; i++) begin
            rd(1'b0, i, v);
            chk("R8 out-of-range write ignored", v, i < NR ? pat(i) : 32'h0);
        end

        // R3 / R4: side effects OR into status words
        wr(1'b0, 4, 32'h0000_0000);
        wr(1'b0, 6, 32'h8000_0000);
        wr(1'b0, 64, 32'h0000_0000);
        wr(1'b0, 0, 32'h1234_5678);
        rd(1'b0, 4, v);  chk("R3 init done bit", v, 32'h0000_0001);
        rd(1'b0, 6, v);  chk("R3 active bit ORed", v, 32'h8000_0001);
        rd(1'b0, 0, v);  chk("R4 start word value", v, 32'h1234_5678);
        wr(1'b0, 4, 32'h0F00_0000);
        wr(1'b0, 0, 32'h0);
        rd(1'b0, 4, v);  chk("R3 other bits kept", v, 32'h0F00_0001);
        rd(1'b0, 0, v);  chk("R4 zero stored", v, 32'h0);
        wr(1'b0, 4, 32'h0000_0001);

        // R5 / R6: timeout disarmed, then armed
        for (int i = 0; i < SPACE; i += 37) begin
            rd(1'b1, i, v); chk("R5 probe read zero", v, 32'h0);
        end
        rd(1'b0, 4, v);  chk("R6 disarmed no timeout", v, 32'h0000_0001);
        wr(1'b0, 64, 32'h0200_0000);
        rd(1'b0, 2, v);
        rd(1'b0, 4, v);  chk("R6 arm alone no timeout", v, 32'h0000_0001);
        for (int i = 0; i < SPACE; i++) begin
            rd(1'b1, i, v); chk("R5 probe read zero armed", v, 32'h0);
        end
        rd(1'b0, 4, v);  chk("R6 timeout set", v, 32'h0000_2001);

        // R7: sticky through further probe reads, disarmed and armed
        wr(1'b0, 64, 32'h0);
        rd(1'b1, 5, v);
        rd(1'b0, 4, v);  chk("R7 sticky disarmed", v, 32'h0000_2001);
        wr(1'b0, 64, 32'h0200_0000);
        rd(1'b1, 9, v);
        rd(1'b0, 4, v);  chk("R7 sticky armed", v, 32'h0000_2001);

        // R9: probe writes ignored
        wr(1'b0, 6, 32'h0);
        wr(1'b1, 4, 32'h0);
        wr(1'b1, 0, 32'hFFFF_FFFF);
        wr(1'b1, 64, 32'h0);
        rd(1'b0, 4, v);  chk("R9 probe write pstat", v, 32'h0000_2001);
        rd(1'b0, 6, v);  chk("R9 no start side effect", v, 32'h0);
        rd(1'b0, 0, v);  chk("R9 start word untouched", v, 32'h0);
        rd(1'b0, 64, v); chk("R9 cfg untouched", v, 32'h0200_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule